// File: doc/BRIEF.md
# Wavefront Crossbar Arbiter

The block decides, once per clock, which crosspoints of an N-by-N crossbar close. Its input is a request matrix in which a set bit means that an input port has traffic for an output port. Its output is a registered grant matrix in which each input and each output carries at most one grant. Inside, a grid of identical cells works out the decision with combinational logic only. Each cell closes its crosspoint when it has a request and both its row and its column are still free. It then passes row availability to its right neighbour and column availability to the neighbour below.

The wave starts at a diagonal cell (s, s) and spreads across the matrix one anti-diagonal at a time. Row and column positions wrap at the matrix edges, so a cell nearer the start in wave order has priority over a cell further away. The start index s moves by one on every clock so that no input or output is favoured over time. To keep the wrapped array free of combinational loops, the request matrix is rotated into a frame relative to s. A plain 2N−1-diagonal grid runs in that frame, and the grants are rotated back afterwards.

Matrix bit `r*N + c` belongs to input (row) r and output (column) c, on both `req_i` and `grant_o`.

Top module: `wfa_arbiter`

## Requirements
- R1: While `rst_ni` is low, and from the moment it falls, `grant_o` is all zeros and the start index is 0. The first decision after release uses start 0.
- R2: A grant bit is set only where the request matrix sampled at the same clock edge had its bit set.
- R3: No row of `grant_o` holds more than one set bit.
- R4: No column of `grant_o` holds more than one set bit.
- R5: The grant is maximal. No requested crosspoint is left ungranted while both its row and its column are grant-free.
- R6: Cell (r, c) has relative position i = (r − s) mod N, j = (c − s) mod N, and its wave index is i + j. Cells are decided in increasing wave index. A cell is granted when it is requested and no earlier-decided cell in its row or its column was granted.
- R7: The start index s is 0 for the first decision after reset and rises by one per clock, going from N−1 back to 0. With only row r requesting every output, that row is granted output s.
- R8: Priority wraps at the edges. With s = N−1 and requests at (N−1, 0) and (0, 0), the grant goes to (N−1, 0).
- R9: An all-zero request matrix yields an all-zero grant after the next clock edge.
- R10: `grant_o` changes only at a clock edge or on reset. A change of `req_i` between edges leaves it untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one arbitration period per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N*N | Request matrix, bit r*N+c = input r wants output c |
| grant_o | output | N*N | Registered grant matrix, same layout as `req_i` |

## Verification
The bench targets the wrapped priority. It fills one row or one column with conflicts and places them at every start value, including N−1. A design that does not wrap at the edges, or that rotates in the wrong direction, hands the contested output to the wrong input. The all-ones matrix and dense random matrices test maximality and uniqueness at the same time. An arbiter that blocks a row too eagerly leaves pairs idle, and one whose column chain is broken double-books an output. Single-row sweeps over more than N cycles expose a start index that stalls, skips or fails to wrap. An asynchronous reset applied mid-run shows whether grants clear at once and whether the start index returns to 0.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

  function automatic int wrap_add(input int a, input int b, input int n);
    int t;
    t = a + b;
    if (t >= n) t -= n;
    return t;
  endfunction

  function automatic int wrap_sub(input int a, input int b, input int n);
    int t;
    t = a - b;
    if (t < 0) t += n;
    return t;
  endfunction

endpackage

// File: rtl/wfa_start_ctr.sv
module wfa_start_ctr #(
  parameter int N = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] start_o
);

  logic [SW-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
    end else if (start_q == SW'(N - 1)) begin
      start_q <= '0;
    end else begin
      start_q <= start_q + SW'(1);
    end
  end

  assign start_o = start_q;

endmodule

// File: rtl/wfa_permute.sv
// Rotates a matrix along both axes by the start index.
// INVERSE=0: absolute -> relative frame, INVERSE=1: relative -> absolute.
module wfa_permute #(
  parameter int N       = 4,
  parameter bit INVERSE = 1'b0,
  localparam int SW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic [SW-1:0] start_i,
  input  logic [NN-1:0] mat_i,
  output logic [NN-1:0] mat_o
);
  import wfa_pkg::*;

  if (INVERSE) begin : g_inv
    always_comb begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          int si, sj;
          si = wrap_sub(r, int'(start_i), N);
          sj = wrap_sub(c, int'(start_i), N);
          mat_o[r*N+c] = mat_i[si*N+sj];
        end
      end
    end
  end else begin : g_fwd
    always_comb begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          int sr, sc;
          sr = wrap_add(i, int'(start_i), N);
          sc = wrap_add(j, int'(start_i), N);
          mat_o[i*N+j] = mat_i[sr*N+sc];
        end
      end
    end
  end

endmodule

// File: rtl/wfa_cell.sv
module wfa_cell (
  input  logic req_i,
  input  logic row_free_i,
  input  logic col_free_i,
  output logic gnt_o,
  output logic row_free_o,
  output logic col_free_o
);

  assign gnt_o      = req_i & row_free_i & col_free_i;
  assign row_free_o = row_free_i & ~gnt_o;
  assign col_free_o = col_free_i & ~gnt_o;

endmodule

// File: rtl/wfa_grid.sv
// Unrolled grid in the start-relative frame: cell (0,0) decides first,
// availability flows right along rows and down along columns.
module wfa_grid #(
  parameter int N = 4,
  localparam int NN = N * N
) (
  input  logic [NN-1:0] req_rel_i,
  output logic [NN-1:0] gnt_rel_o,
  output logic [N-1:0]  row_open_o,
  output logic [N-1:0]  col_open_o
);

  logic [N*(N+1)-1:0] rf_chain;
  logic [(N+1)*N-1:0] cf_chain;

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rf_chain[i*(N+1)]   = 1'b1;
    assign row_open_o[i]       = rf_chain[i*(N+1)+N];
    assign cf_chain[i]         = 1'b1;
    assign col_open_o[i]       = cf_chain[N*N+i];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      wfa_cell u_cell (
        .req_i      (req_rel_i[i*N+j]),
        .row_free_i (rf_chain[i*(N+1)+j]),
        .col_free_i (cf_chain[i*N+j]),
        .gnt_o      (gnt_rel_o[i*N+j]),
        .row_free_o (rf_chain[i*(N+1)+j+1]),
        .col_free_o (cf_chain[(i+1)*N+j])
      );
    end
  end

endmodule

// File: rtl/wfa_arbiter.sv
module wfa_arbiter #(
  parameter int N = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NN-1:0] req_i,
  output logic [NN-1:0] grant_o
);

  logic [SW-1:0] start_q;
  logic [NN-1:0] req_rel;
  logic [NN-1:0] gnt_rel;
  logic [NN-1:0] gnt_abs;
  logic [N-1:0]  row_open;
  logic [N-1:0]  col_open;
  logic [NN-1:0] grant_q;

  wfa_start_ctr #(.N(N)) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_o (start_q)
  );

  wfa_permute #(.N(N), .INVERSE(1'b0)) u_to_rel (
    .start_i (start_q),
    .mat_i   (req_i),
    .mat_o   (req_rel)
  );

  wfa_grid #(.N(N)) u_grid (
    .req_rel_i  (req_rel),
    .gnt_rel_o  (gnt_rel),
    .row_open_o (row_open),
    .col_open_o (col_open)
  );

  wfa_permute #(.N(N), .INVERSE(1'b1)) u_to_abs (
    .start_i (start_q),
    .mat_i   (gnt_rel),
    .mat_o   (gnt_abs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_q <= '0;
    else         grant_q <= gnt_abs;
  end

  assign grant_o = grant_q;

endmodule

// File: rtl/wfa_arbiter_chk.sv
module wfa_arbiter_chk #(
  parameter int N = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NN-1:0] req_i,
  input logic [NN-1:0] grant_i,
  input logic [SW-1:0] start_i,
  input logic [N-1:0]  row_open_i,
  input logic [N-1:0]  col_open_i
);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  function automatic logic unserved(input logic [NN-1:0] rq, input logic [NN-1:0] g);
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        if (rq[r*N+c]) begin
          logic rb, cb;
          rb = |g[r*N +: N];
          cb = 1'b0;
          for (int k = 0; k < N; k++) cb |= g[k*N+c];
          if (!rb && !cb) return 1'b1;
        end
      end
    end
    return 1'b0;
  endfunction

  function automatic logic [SW-1:0] next_start(input logic [SW-1:0] s);
    if (s == SW'(N - 1)) return '0;
    return s + SW'(1);
  endfunction

  logic [N-1:0] col_bits [N];
  always_comb begin
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++)
        col_bits[c][r] = grant_i[r*N+c];
  end

  for (genvar r = 0; r < N; r++) begin : g_rowchk
    assert_row_unique_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(grant_i[r*N +: N]) <= 1);
  end

  for (genvar c = 0; c < N; c++) begin : g_colchk
    assert_col_unique_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col_bits[c]) <= 1);
  end

  assert_grant_requested_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((grant_i & ~$past(req_i)) == '0));

  assert_maximal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> !unserved($past(req_i), grant_i));

  // R3: every row ends the wave either granted or still open
  assert_row_account_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ($countones(grant_i) + $countones($past(row_open_i)) == N));

  // R4: same accounting for columns
  assert_col_account_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ($countones(grant_i) + $countones($past(col_open_i)) == N));

  assert_start_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (start_i == next_start($past(start_i))));

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(req_i) == '0) |-> (grant_i == '0));

endmodule

bind wfa_arbiter wfa_arbiter_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .grant_i    (grant_o),
  .start_i    (start_q),
  .row_open_i (row_open),
  .col_open_i (col_open)
);

// File: tb/tb_wfa_arbiter.sv
`timescale 1ns/1ps
module tb_wfa_arbiter;
  localparam int N  = 4;
  localparam int NN = N * N;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NN-1:0] req_i = '0;
  logic [NN-1:0] grant_o;

  int total = 0;
  int bad   = 0;
  int s_m   = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wfa_arbiter #(.N(N)) dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .grant_o (grant_o)
  );

  // behavioural reference: visit cells in wave order from start (s,s)
  function automatic logic [NN-1:0] wave_ref(input logic [NN-1:0] r, input int s);
    logic [NN-1:0] g;
    bit ru [N];
    bit cu [N];
    g = '0;
    for (int k = 0; k < N; k++) begin ru[k] = 0; cu[k] = 0; end
    for (int t = 0; t <= 2*N-2; t++) begin
      for (int i = 0; i < N; i++) begin
        int j, rr, cc;
        j = t - i;
        if (j >= 0 && j < N) begin
          rr = (i + s) % N;
          cc = (j + s) % N;
          if (r[rr*N+cc] && !ru[rr] && !cu[cc]) begin
            g[rr*N+cc] = 1'b1;
            ru[rr] = 1;
            cu[cc] = 1;
          end
        end
      end
    end
    return g;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NN-1:0] act,
                     input logic [NN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit rows_ok(input logic [NN-1:0] g);
    for (int r = 0; r < N; r++) if ($countones(g[r*N +: N]) > 1) return 0;
    return 1;
  endfunction

  function automatic bit cols_ok(input logic [NN-1:0] g);
    for (int c = 0; c < N; c++) begin
      int n;
      n = 0;
      for (int r = 0; r < N; r++) n += int'(g[r*N+c]);
      if (n > 1) return 0;
    end
    return 1;
  endfunction

  function automatic bit maximal(input logic [NN-1:0] rq, input logic [NN-1:0] g);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if (rq[r*N+c]) begin
          bit busy;
          busy = |g[r*N +: N];
          for (int k = 0; k < N; k++) busy |= g[k*N+c];
          if (!busy) return 0;
        end
    return 1;
  endfunction

  // called at a negedge: drive, wait one edge, check at the next negedge
  task automatic run_cycle(input logic [NN-1:0] r, input string tag);
    logic [NN-1:0] exp;
    req_i = r;
    @(posedge clk_i);
    @(negedge clk_i);
    exp = wave_ref(r, s_m);
    chk(grant_o == exp, tag, grant_o, exp);
    chk((grant_o & ~r) == '0, "R2 grant without request", grant_o, grant_o & r);
    chk(rows_ok(grant_o), "R3 row unique", grant_o, exp);
    chk(cols_ok(grant_o), "R4 column unique", grant_o, exp);
    chk(maximal(r, grant_o), "R5 maximal", grant_o, exp);
    s_m = (s_m + 1) % N;
  endtask

  function automatic logic [NN-1:0] row_all(input int r);
    logic [NN-1:0] m;
    m = '0;
    m[r*N +: N] = '1;
    return m;
  endfunction

  initial begin
    logic [NN-1:0] held, m;
    // R1: reset state, with requests present
    req_i = '1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(grant_o == '0, "R1 reset grant", grant_o, '0);
    req_i = '0;
    rst_ni = 1'b1;
    s_m = 0;

    // R9: idle
    run_cycle('0, "R9 no requests");
    run_cycle('0, "R9 no requests");

    // R7: one row asks for all outputs, grant follows the start index
    for (int k = 0; k < N + 2; k++) begin
      int exp_c;
      exp_c = s_m;
      run_cycle(row_all(N/2), "R7 row sweep");
      m = '0;
      m[(N/2)*N + exp_c] = 1'b1;
      chk(grant_o == m, "R7 start column", grant_o, m);
    end

    // R6: full matrix gives a complete matching
    for (int k = 0; k < N; k++) begin
      run_cycle('1, "R6 all ones");
      chk($countones(grant_o) == N, "R5 full matching", grant_o, '1);
    end

    // R8: wrap priority at start N-1
    while (s_m != N - 1) run_cycle('0, "R9 idle fill");
    m = '0;
    m[(N-1)*N] = 1'b1;
    m[0] = 1'b1;
    run_cycle(m, "R8 wrap");
    held = '0;
    held[(N-1)*N] = 1'b1;
    chk(grant_o == held, "R8 wrap winner", grant_o, held);

    // R6: contested column across all starts
    for (int k = 0; k < 2 * N; k++) begin
      m = '0;
      for (int r = 0; r < N; r++) m[r*N + 1] = 1'b1;
      run_cycle(m, "R6 column conflict");
    end

    // R10: mid-period request change does not move the grant
    run_cycle('1, "R6 all ones");
    held = grant_o;
    req_i = '0;
    #1;
    chk(grant_o == held, "R10 hold between edges", grant_o, held);
    @(negedge clk_i);
    chk(grant_o == '0, "R9 after hold", grant_o, '0);
    s_m = (s_m + 1) % N;

    // R6: random traffic
    for (int k = 0; k < 300; k++) begin
      m = NN'($urandom());
      if (k % 3 == 0) m = m & NN'($urandom());
      run_cycle(m, "R6 random");
    end

    // R1: asynchronous reset mid-run
    run_cycle('1, "R6 all ones");
    rst_ni = 1'b0;
    #1;
    chk(grant_o == '0, "R1 async clear", grant_o, '0);
    @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    s_m = 0;
    run_cycle(row_all(0), "R1 restart start");
    m = '0;
    m[0] = 1'b1;
    chk(grant_o == m, "R1 start back at 0", grant_o, m);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule